// File: doc/BRIEF.md
# Dual-Format Pulse-Width Modulator

This block produces a periodic pulse on one output pin. It advances one step on each clock cycle where the count-enable strobe is high while the start input is set. A single 16-bit value, always written as a whole word, configures the block. The value is read in one of two formats, chosen by a format-select input.

In the wide format, the whole word is the high time, and a frame has a fixed length of 65535 steps. In the split format, the low byte is a prescale factor m and the high byte is a coarse high-time count n. A frame then lasts 255·(m+1) steps, and the pin is high for (m+1)·n of them.

A value that gives a zero high time turns the modulator off. The pin stays low and no interrupt is raised. A new value and format take effect only at a frame boundary. A one-cycle interrupt pulse marks the end of every active frame.

Top module: `dual_pwm`

## Requirements
- R1: After reset, `pwm_o` and `irq_o` are low.
- R2: With `fmt8_i`=0, a frame lasts 65535 steps and `pwm_o` is high for the first n steps, where n=`wr_data_i[15:0]`. The pin rises in the cycle after the first step of the frame.
- R3: With `fmt8_i`=1, a frame lasts 255·(m+1) steps, where m=`wr_data_i[7:0]`.
- R4: With `fmt8_i`=1, `pwm_o` is high for (m+1)·n steps at the start of each frame, where n=`wr_data_i[15:8]`.
- R5: A value of 0000h keeps `pwm_o` low and `irq_o` low.
- R6: With `fmt8_i`=1, a high byte of 00h keeps `pwm_o` and `irq_o` low, whatever the low byte holds.
- R7: A word written mid-frame, and the state of `fmt8_i`, take effect only at the next frame boundary. The frame in progress completes with its old settings.
- R8: `irq_o` is high for exactly one cycle after the last step of each active frame. When the strobe is held high, that cycle is the one just before `pwm_o` rises again.
- R9: Steps occur only on cycles where `cnt_en_i` and `start_i` are both high. Dropping `start_i` drives `pwm_o` low on the next cycle and returns the block to a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count-enable strobe, one step per high cycle |
| wr_en_i | input | 1 | Writes `wr_data_i` into the configuration word |
| wr_data_i | input | 16 | Configuration word |
| start_i | input | 1 | Runs the modulator while high |
| fmt8_i | input | 1 | 0: wide format, 1: split format |
| pwm_o | output | 1 | Modulated output |
| irq_o | output | 1 | End-of-frame interrupt pulse |

## Verification
The assertions assume that `fmt8_i` and any new word matter only at a step that opens a frame. They also assume the counter bound is taken from the settings latched for the frame in progress. The stimulus therefore holds `fmt8_i` steady while a frame runs. It writes mid-frame only to exercise the boundary latch, and it changes format only while stopped. Split-format high bytes stay below FFh, so every frame has a falling edge for the monitor to time.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  parameter int unsigned PWM_W = 16;
  typedef enum logic {FMT_WIDE = 1'b0, FMT_SPLIT = 1'b1} fmt_e;
endpackage

// File: rtl/dpwm_cfg.sv
module dpwm_cfg import dpwm_pkg::*; #(
  parameter int unsigned W  = PWM_W,
  parameter int unsigned HB = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  fmt_e          fmt_i,
  input  logic          load_i,
  output logic [W-1:0]  hi_o,
  output logic [HB-1:0] pre_o,
  output logic [W-1:0]  lim_o,
  output logic          run_o
);
  localparam logic [W-1:0] WIDE_LIM = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] HALF_LIM = {{(W-HB){1'b0}}, {(HB-1){1'b1}}, 1'b0};

  logic [W-1:0] shadow_q, act_q, cur_val;
  fmt_e         act_fmt_q, cur_fmt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      shadow_q <= '0;
    else if (wr_en_i) shadow_q <= wr_data_i;

  // frame settings swap only on the opening step of a frame
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      act_q     <= '0;
      act_fmt_q <= FMT_WIDE;
    end else if (load_i) begin
      act_q     <= cur_val;
      act_fmt_q <= cur_fmt;
    end

  assign cur_val = load_i ? shadow_q : act_q;
  assign cur_fmt = load_i ? fmt_i    : act_fmt_q;

  always_comb begin
    if (cur_fmt == FMT_SPLIT) begin
      hi_o  = {{(W-HB){1'b0}}, cur_val[W-1:HB]};
      pre_o = cur_val[HB-1:0];
      lim_o = HALF_LIM;
      run_o = |cur_val[W-1:HB];
    end else begin
      hi_o  = cur_val;
      pre_o = '0;
      lim_o = WIDE_LIM;
      run_o = |cur_val;
    end
  end
endmodule

// File: rtl/dpwm_cnt.sv
module dpwm_cnt #(
  parameter int unsigned W  = 16,
  parameter int unsigned HB = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [HB-1:0] pre_i,
  input  logic [W-1:0]  lim_i,
  output logic [W-1:0]  coarse_o,
  output logic          at_start_o,
  output logic          last_o
);
  logic [HB-1:0] fine_q;
  logic [W-1:0]  coarse_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else if (clr_i) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else if (tick_i && run_i) begin
      if (fine_q == pre_i) begin
        fine_q   <= '0;
        coarse_q <= (coarse_q == lim_i) ? '0 : coarse_q + 1'b1;
      end else begin
        fine_q <= fine_q + 1'b1;
      end
    end

  assign coarse_o   = coarse_q;
  assign at_start_o = (coarse_q == '0) && (fine_q == '0);
  assign last_o     = (coarse_q == lim_i) && (fine_q == pre_i);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_q <= lim_i);  // R3
  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> at_start_o);  // R9
endmodule

// File: rtl/dpwm_out.sv
module dpwm_out #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         last_i,
  input  logic [W-1:0] coarse_i,
  input  logic [W-1:0] hi_i,
  output logic         pwm_o,
  output logic         irq_o
);
  logic pwm_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (clr_i) begin
      pwm_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (tick_i) pwm_q <= run_i && (coarse_i < hi_i);
      irq_q <= tick_i && run_i && last_i;
    end

  assign pwm_o = pwm_q;
  assign irq_o = irq_q;

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);  // R8
  AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!pwm_q && !irq_q));  // R9
endmodule

// File: rtl/dual_pwm.sv
module dual_pwm import dpwm_pkg::*; #(
  parameter int unsigned W = PWM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         start_i,
  input  logic         fmt8_i,
  output logic         pwm_o,
  output logic         irq_o
);
  localparam int unsigned HB = W / 2;

  logic          tick, clr, load, run, at_start, last;
  logic [W-1:0]  hi, lim, coarse;
  logic [HB-1:0] pre;

  assign tick = start_i & cnt_en_i;
  assign clr  = ~start_i;
  assign load = tick & at_start;

  dpwm_cfg #(.W(W), .HB(HB)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .fmt_i(fmt_e'(fmt8_i)), .load_i(load),
    .hi_o(hi), .pre_o(pre), .lim_o(lim), .run_o(run)
  );

  dpwm_cnt #(.W(W), .HB(HB)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(tick), .run_i(run),
    .pre_i(pre), .lim_i(lim),
    .coarse_o(coarse), .at_start_o(at_start), .last_o(last)
  );

  dpwm_out #(.W(W)) u_out (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(tick), .run_i(run),
    .last_i(last), .coarse_i(coarse), .hi_i(hi),
    .pwm_o, .irq_o
  );

  AST_RISE_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> $past(load));  // R7
  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !run) |=> (!pwm_o && !irq_o));  // R5 R6
endmodule

// File: tb/dual_pwm_tb_top.sv
module dual_pwm_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        cnt_en = 1'b1, wr_en = 1'b0, start = 1'b0, fmt8 = 1'b0;
  logic [15:0] wr_data = '0;
  logic        pwm, irq;

  dual_pwm dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .start_i(start), .fmt8_i(fmt8),
    .pwm_o(pwm), .irq_o(irq)
  );

  typedef struct { int hi; int per; bit irq_adj; string req; } item_t;
  item_t exp_q[$];
  item_t e;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: times frames and compares against the queue
  bit prev_pwm = 0, prev_irq = 0, have_prev = 0;
  int hi_cnt = 0, last_hi = 0, per_cnt = 0, hi_samples = 0, irq_samples = 0;
  always @(posedge clk) begin
    #2;
    if (!start) have_prev = 0;
    else begin
      if (pwm) hi_samples++;
      if (irq) irq_samples++;
      if (pwm && !prev_pwm) begin
        if (have_prev) begin
          if (exp_q.size() == 0) check("R7", "unexpected frame", 1, 0);
          else begin
            e = exp_q.pop_front();
            check(e.req, "high time", last_hi, e.hi);
            check(e.req, "period", per_cnt, e.per);
            if (e.irq_adj) check("R8", "irq before rise", int'(prev_irq), 1);
          end
        end
        have_prev = 1; per_cnt = 1; hi_cnt = 1;
      end else begin
        per_cnt++;
        if (pwm) hi_cnt++;
      end
      if (!pwm && prev_pwm) last_hi = hi_cnt;
    end
    prev_pwm = pwm;
    prev_irq = irq;
  end

  task automatic wr(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic push(input int hi, input int per, input bit adj, input string req);
    item_t it;
    it.hi = hi; it.per = per; it.irq_adj = adj; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic stop(input string req);
    start = 1'b0;
    @(negedge clk);
    check("R9", "pwm low after stop", int'(pwm), 0);
    repeat (2) @(negedge clk);
    check(req, "frames outstanding", exp_q.size(), 0);
  endtask

  task automatic run(input int cycles, input string req);
    @(negedge clk); start = 1'b1;
    repeat (cycles) @(negedge clk);
    stop(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "pwm after reset", int'(pwm), 0);
    check("R1", "irq after reset", int'(irq), 0);

    // split format, m=0 n=3
    fmt8 = 1'b1;
    wr(16'h0300);
    push(3, 255, 1, "R3"); push(3, 255, 1, "R4");
    run(255 * 2 + 4, "R3");

    // split format, m=3 n=10
    wr(16'h0A03);
    push(40, 1020, 1, "R4");
    run(1024, "R4");

    // mid-frame write waits for the boundary
    wr(16'h0501);
    push(10, 510, 1, "R7"); push(7, 255, 1, "R7");
    @(negedge clk); start = 1'b1;
    repeat (100) @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h0700;
    @(negedge clk); wr_en = 1'b0;
    repeat (510 + 255 + 4 - 101) @(negedge clk);
    stop("R7");

    // all-zero word in wide format
    fmt8 = 1'b0;
    wr(16'h0000);
    hi_samples = 0; irq_samples = 0;
    run(600, "R5");
    check("R5", "high samples", hi_samples, 0);
    check("R5", "irq samples", irq_samples, 0);

    // zero high byte in split format
    fmt8 = 1'b1;
    wr(16'h00FF);
    hi_samples = 0; irq_samples = 0;
    run(600, "R6");
    check("R6", "high samples", hi_samples, 0);
    check("R6", "irq samples", irq_samples, 0);

    // strobe every other cycle doubles all times
    wr(16'h0200);
    push(4, 510, 0, "R9");
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < 516; i++) begin
      cnt_en = i[0];
      @(negedge clk);
    end
    cnt_en = 1'b1;
    stop("R9");

    // wide format, n=256
    fmt8 = 1'b0;
    wr(16'h0100);
    push(256, 65535, 1, "R2");
    run(65535 + 4, "R2");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule